// File: doc/BRIEF.md
# Store Buffer With Load Bypass

This block sits between a processor's memory port and its data cache. It takes word-sized stores from the processor and keeps them in a small circular buffer. It then sends them to the cache over a valid/ready write channel. Each entry covers one cache block: a block address, one valid bit per word and a data lane per word. A write to the cache carries that mask, so the cache updates only the words that were stored.

The `MODE` parameter picks one of two behaviours. In FIFO mode every accepted store gets its own entry, and entries are offered to the cache as soon as they exist, oldest first. In merge mode a store to a block that already has an entry, and that entry is not being offered right now, is folded into that entry. Merge-mode entries stay in the buffer until the buffer is full or a drain is in progress, which gives later stores a chance to merge.

Loads are looked up against the pending entries in the same cycle. A hit returns the word from the youngest entry that holds it. A miss, including a block that is present but lacks the word, goes unchanged to the cache read port. A completion pulse marks the write of each entry that supplied forwarded data. A drain request stops new stores until the buffer is empty.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the buffer holds nothing: `empty_o` is 1, `wr_valid_o` is 0, `ld_cmpl_o` is 0 and `st_ready_o` is 1.
- R2: In FIFO mode each accepted store occupies one entry. Its `wr_mask_o` has exactly the one bit of its word set. Entries are offered whenever the buffer is not empty, in the order the stores were accepted.
- R3: Addresses are word addresses. The low log2(WPB) bits select the word in the block, and the rest form the block address on `wr_addr_o`. Word k maps to `wr_mask_o[k]` and to `wr_data_o[k*DW +: DW]`. In merge mode, a store whose block matches a pending entry that is not being offered sets that word's mask bit and overwrites that word. No new entry is created.
- R4: In merge mode `wr_valid_o` is asserted only when all DEPTH entries are in use or a drain is in progress.
- R5: A load whose word is valid in a pending entry returns, in the same cycle, `ld_hit_o`=1 and the data of the youngest such entry. The lookup uses the contents as they stood before this cycle's store.
- R6: A load with no valid matching word asserts `rd_valid_o` with `rd_addr_o` equal to `ld_addr_i` and leaves `ld_hit_o` at 0.
- R7: `ld_cmpl_o` is 1 exactly in a cycle where the entry being written to the cache (valid and ready both high) has supplied data to a load, in that cycle or any earlier one.
- R8: `st_ready_o` is 0 when all entries are in use and the store has no merge target.
- R9: After `drain_i`, stores are refused from the next cycle until the buffer is empty, and entries are offered regardless of mode. `empty_o` is 1 exactly when no entry is pending.
- R10: While `wr_valid_o` is 1 and `wr_ready_i` is 0, the offered address, mask and data stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Store accepted this cycle when high with st_valid_i |
| st_addr_i | input | AW | Store word address |
| st_data_i | input | DW | Store data |
| ld_valid_i | input | 1 | Load lookup request |
| ld_addr_i | input | AW | Load word address |
| ld_hit_o | output | 1 | Load served from the buffer |
| ld_data_o | output | DW | Forwarded load data (zero when no hit) |
| rd_valid_o | output | 1 | Load passed to the cache read port |
| rd_addr_o | output | AW | Cache read word address |
| ld_cmpl_o | output | 1 | Entry that fed a forwarded load is written this cycle |
| wr_valid_o | output | 1 | Cache write offered |
| wr_ready_i | input | 1 | Cache accepts the write |
| wr_addr_o | output | AW-log2(WPB) | Block address of the write |
| wr_mask_o | output | WPB | Words of the block being written |
| wr_data_o | output | WPB*DW | Block data, lane per word |
| drain_i | input | 1 | Request to empty the buffer |
| empty_o | output | 1 | No pending entry |

## Verification
The checks assume that `wr_ready_i` and `drain_i` may change on any cycle, and that a store need not stay asserted once it has been refused. No handshake discipline is required from the processor side. What is required is that a store address or load address is a whole word address inside the buffer's address space. The stimulus follows that rule by drawing addresses only from a small window of a few blocks, so merges and forwarding hits are frequent. Ready, drain and both request types are driven from independent random draws that change away from the clock edge.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic {MODE_FIFO = 1'b0, MODE_MERGE = 1'b1} wb_mode_e;
endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl #(
  parameter int DEPTH = 4,
  parameter bit HOLD  = 1'b0,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             drain_i,
  output logic [PW-1:0]    head_o,
  output logic [PW-1:0]    tail_o,
  output logic [DEPTH-1:0] vld_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             dact_o,
  output logic             offer_o
);
  logic [PW-1:0] head_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          dact_q;

  assign cnt_nxt = cnt_q + CW'(push_i) - CW'(pop_i);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = head_q;
  assign tail_o  = head_q + cnt_q[PW-1:0];
  assign dact_o  = dact_q;
  // merge mode keeps entries until full or draining
  assign offer_o = !empty_o && (!HOLD || full_o || dact_q);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] age;
      age = PW'(i) - head_q;
      vld_o[i] = (CW'(age) < cnt_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
      dact_q <= 1'b0;
    end else begin
      if (pop_i) head_q <= head_q + 1'b1;
      cnt_q  <= cnt_nxt;
      dact_q <= (dact_q || drain_i) && (cnt_nxt != '0);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> !full_o); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R2
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int DEPTH = 4,
  parameter int BAW   = 10,
  parameter int WPB   = 4,
  parameter bit USE_WORD = 1'b1,
  localparam int PW = $clog2(DEPTH),
  localparam int WO = $clog2(WPB)
) (
  input  logic [DEPTH-1:0]          vld_i,
  input  logic [DEPTH-1:0]          excl_i,
  input  logic [PW-1:0]             head_i,
  input  logic [DEPTH-1:0][BAW-1:0] addr_i,
  input  logic [DEPTH-1:0][WPB-1:0] mask_i,
  input  logic [BAW-1:0]            q_blk_i,
  input  logic [WO-1:0]             q_word_i,
  output logic                      hit_o,
  output logic [PW-1:0]             idx_o
);
  // scan oldest to youngest; the last match is the youngest
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] e;
      e = head_i + PW'(k);
      if (vld_i[e] && !excl_i[e] && addr_i[e] == q_blk_i &&
          (!USE_WORD || mask_i[e][q_word_i])) begin
        hit_o = 1'b1;
        idx_o = e;
      end
    end
  end
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
  import wbuf_pkg::*;
#(
  parameter int       DEPTH = 4,
  parameter int       AW    = 12,
  parameter int       DW    = 32,
  parameter int       WPB   = 4,
  parameter wb_mode_e MODE  = MODE_FIFO,
  localparam int WO  = $clog2(WPB),
  localparam int BAW = AW - WO,
  localparam int PW  = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               st_valid_i,
  output logic               st_ready_o,
  input  logic [AW-1:0]      st_addr_i,
  input  logic [DW-1:0]      st_data_i,
  input  logic               ld_valid_i,
  input  logic [AW-1:0]      ld_addr_i,
  output logic               ld_hit_o,
  output logic [DW-1:0]      ld_data_o,
  output logic               rd_valid_o,
  output logic [AW-1:0]      rd_addr_o,
  output logic               ld_cmpl_o,
  output logic               wr_valid_o,
  input  logic               wr_ready_i,
  output logic [BAW-1:0]     wr_addr_o,
  output logic [WPB-1:0]     wr_mask_o,
  output logic [WPB*DW-1:0]  wr_data_o,
  input  logic               drain_i,
  output logic               empty_o
);
  localparam bit MERGE = (MODE == MODE_MERGE);

  logic [DEPTH-1:0][BAW-1:0]         e_addr;
  logic [DEPTH-1:0][WPB-1:0]         e_mask;
  logic [DEPTH-1:0][WPB-1:0][DW-1:0] e_data;
  logic [DEPTH-1:0]                  e_wait;

  logic [PW-1:0]    head, tail, l_idx, m_idx;
  logic [DEPTH-1:0] vld, excl;
  logic             full, dact, offer, pop, alloc, st_fire, l_hit, m_hit;

  logic [BAW-1:0] st_blk, ld_blk;
  logic [WO-1:0]  st_word, ld_word;
  assign st_blk  = st_addr_i[AW-1:WO];
  assign st_word = st_addr_i[WO-1:0];
  assign ld_blk  = ld_addr_i[AW-1:WO];
  assign ld_word = ld_addr_i[WO-1:0];

  assign pop     = offer && wr_ready_i;
  assign st_ready_o = !dact && (!full || m_hit);
  assign st_fire = st_valid_i && st_ready_o;
  assign alloc   = st_fire && !m_hit;

  wbuf_ctrl #(.DEPTH(DEPTH), .HOLD(MERGE)) u_ctrl (
    .clk_i, .rst_ni,
    .push_i(alloc), .pop_i(pop), .drain_i,
    .head_o(head), .tail_o(tail), .vld_o(vld),
    .full_o(full), .empty_o(empty_o), .dact_o(dact), .offer_o(offer)
  );

  wbuf_match #(.DEPTH(DEPTH), .BAW(BAW), .WPB(WPB), .USE_WORD(1'b1)) u_ld_match (
    .vld_i(vld), .excl_i('0), .head_i(head), .addr_i(e_addr), .mask_i(e_mask),
    .q_blk_i(ld_blk), .q_word_i(ld_word), .hit_o(l_hit), .idx_o(l_idx)
  );

  generate
    if (MERGE) begin : g_merge
      // the entry on offer is frozen, so it cannot take a merge
      always_comb begin
        excl = '0;
        excl[head] = offer;
      end
      wbuf_match #(.DEPTH(DEPTH), .BAW(BAW), .WPB(WPB), .USE_WORD(1'b0)) u_st_match (
        .vld_i(vld), .excl_i(excl), .head_i(head), .addr_i(e_addr), .mask_i(e_mask),
        .q_blk_i(st_blk), .q_word_i(st_word), .hit_o(m_hit), .idx_o(m_idx)
      );
      AST_HOLD_UNTIL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> full || dact); // R4
    end else begin : g_fifo
      assign excl  = '0;
      assign m_hit = 1'b0;
      assign m_idx = '0;
      AST_ONE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> $onehot(wr_mask_o)); // R2
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_addr <= '0;
      e_mask <= '0;
      e_data <= '0;
      e_wait <= '0;
    end else begin
      if (ld_valid_i && l_hit) e_wait[l_idx] <= 1'b1;
      if (st_fire && m_hit) begin
        e_mask[m_idx][st_word] <= 1'b1;
        e_data[m_idx][st_word] <= st_data_i;
      end
      if (pop) begin
        e_mask[head] <= '0;
        e_wait[head] <= 1'b0;
      end
      if (alloc) begin
        e_addr[tail] <= st_blk;
        e_mask[tail] <= WPB'(1) << st_word;
        e_data[tail] <= '0;
        e_data[tail][st_word] <= st_data_i;
        e_wait[tail] <= 1'b0;
      end
    end
  end

  assign ld_hit_o   = ld_valid_i && l_hit;
  assign ld_data_o  = ld_hit_o ? e_data[l_idx][ld_word] : '0;
  assign rd_valid_o = ld_valid_i && !l_hit;
  assign rd_addr_o  = ld_addr_i;

  assign wr_valid_o = offer;
  assign wr_addr_o  = e_addr[head];
  assign wr_mask_o  = e_mask[head];
  assign wr_data_o  = e_data[head];
  assign ld_cmpl_o  = pop && (e_wait[head] || (ld_hit_o && l_idx == head));

  AST_WR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) &&
    $stable(wr_mask_o) && $stable(wr_data_o)); // R10
  AST_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !wr_valid_o); // R9
  AST_DRAIN_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_i |=> empty_o || !st_ready_o); // R9
  AST_CMPL_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_cmpl_o |-> wr_valid_o && wr_ready_i); // R7
  AST_MASK_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> wr_mask_o != '0); // R3
endmodule

// File: tb/wbuf_bypass_tb.sv
module wbuf_bypass_tb;
  import wbuf_pkg::*;
  localparam int DEPTH = 4, AW = 12, DW = 32, WPB = 4;
  localparam int WO = $clog2(WPB), BAW = AW - WO, LW = WPB * DW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic st_valid = 0, ld_valid = 0, wr_ready = 0, drain = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;

  logic           st_ready[2], ld_hit[2], rd_valid[2], ld_cmpl[2], wr_valid[2], empty[2];
  logic [DW-1:0]  ld_data[2];
  logic [AW-1:0]  rd_addr[2];
  logic [BAW-1:0] wr_addr[2];
  logic [WPB-1:0] wr_mask[2];
  logic [LW-1:0]  wr_data[2];

  wbuf_bypass #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .WPB(WPB), .MODE(MODE_FIFO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .st_valid_i(st_valid), .st_ready_o(st_ready[0]),
    .st_addr_i(st_addr), .st_data_i(st_data), .ld_valid_i(ld_valid), .ld_addr_i(ld_addr),
    .ld_hit_o(ld_hit[0]), .ld_data_o(ld_data[0]), .rd_valid_o(rd_valid[0]), .rd_addr_o(rd_addr[0]),
    .ld_cmpl_o(ld_cmpl[0]), .wr_valid_o(wr_valid[0]), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr[0]), .wr_mask_o(wr_mask[0]), .wr_data_o(wr_data[0]),
    .drain_i(drain), .empty_o(empty[0]));

  wbuf_bypass #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .WPB(WPB), .MODE(MODE_MERGE)) u_dut_m (
    .clk_i(clk), .rst_ni(rst_n), .st_valid_i(st_valid), .st_ready_o(st_ready[1]),
    .st_addr_i(st_addr), .st_data_i(st_data), .ld_valid_i(ld_valid), .ld_addr_i(ld_addr),
    .ld_hit_o(ld_hit[1]), .ld_data_o(ld_data[1]), .rd_valid_o(rd_valid[1]), .rd_addr_o(rd_addr[1]),
    .ld_cmpl_o(ld_cmpl[1]), .wr_valid_o(wr_valid[1]), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr[1]), .wr_mask_o(wr_mask[1]), .wr_data_o(wr_data[1]),
    .drain_i(drain), .empty_o(empty[1]));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model: one entry queue per mode
  logic [BAW-1:0] qa[2][$];
  logic [WPB-1:0] qm[2][$];
  logic [LW-1:0]  qd[2][$];
  bit             qw[2][$];
  bit             dact[2];
  bit             prev_stall[2];

  task automatic chk(input string req, input int m, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d t=%0t actual=%h expected=%h", req, m, $time, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] lanes(input logic [WPB-1:0] msk);
    logic [LW-1:0] r;
    for (int k = 0; k < WPB; k++) r[k*DW +: DW] = {DW{msk[k]}};
    return r;
  endfunction

  task automatic step(input bit sv, input int sa, input int sd, input bit lv, input int la,
                      input bit wr, input bit dr);
    bit offer[2], fire[2], mh[2], stf[2], lh[2];
    int mj[2], lj[2];
    st_valid = sv; st_addr = AW'(sa); st_data = DW'(sd);
    ld_valid = lv; ld_addr = AW'(la); wr_ready = wr; drain = dr;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      int cnt;
      logic [LW-1:0] ed;
      cnt = qa[m].size();
      offer[m] = cnt > 0 && (m == 0 || cnt == DEPTH || dact[m]);
      fire[m]  = offer[m] && wr;
      mh[m] = 0; mj[m] = 0;
      if (m == 1)
        for (int j = 0; j < cnt; j++)
          if (!(j == 0 && offer[m]) && qa[m][j] == BAW'(sa >> WO)) begin mh[m] = 1; mj[m] = j; end
      stf[m] = sv && !dact[m] && (cnt < DEPTH || mh[m]);
      lh[m] = 0; lj[m] = 0;
      for (int j = 0; j < cnt; j++)
        if (qa[m][j] == BAW'(la >> WO) && qm[m][j][la % WPB]) begin lh[m] = 1; lj[m] = j; end
      chk("R8 st_ready", m, LW'(st_ready[m]), LW'(!dact[m] && (cnt < DEPTH || mh[m])));
      chk(m == 0 ? "R2 wr_valid" : "R4 wr_valid", m, LW'(wr_valid[m]), LW'(offer[m]));
      chk("R9 empty", m, LW'(empty[m]), LW'(cnt == 0));
      if (offer[m]) begin
        chk(m == 0 ? "R2 wr_addr" : "R3 wr_addr", m, LW'(wr_addr[m]), LW'(qa[m][0]));
        chk(m == 0 ? "R2 wr_mask" : "R3 wr_mask", m, LW'(wr_mask[m]), LW'(qm[m][0]));
        ed = qd[m][0];
        chk(prev_stall[m] ? "R10 wr_data" : "R3 wr_data", m,
            wr_data[m] & lanes(qm[m][0]), ed & lanes(qm[m][0]));
      end
      chk("R5 ld_hit", m, LW'(ld_hit[m]), LW'(lv && lh[m]));
      if (lv && lh[m]) begin
        ed = qd[m][lj[m]];
        chk("R5 ld_data", m, LW'(ld_data[m]), LW'(ed[(la % WPB)*DW +: DW]));
      end
      chk("R6 rd_valid", m, LW'(rd_valid[m]), LW'(lv && !lh[m]));
      if (lv && !lh[m]) chk("R6 rd_addr", m, LW'(rd_addr[m]), LW'(la));
      chk("R7 ld_cmpl", m, LW'(ld_cmpl[m]),
          LW'(fire[m] && (qw[m][0] || (lv && lh[m] && lj[m] == 0))));
    end
    @(posedge clk);
    for (int m = 0; m < 2; m++) begin
      logic [LW-1:0] d;
      prev_stall[m] = offer[m] && !wr;
      if (lv && lh[m]) qw[m][lj[m]] = 1;
      if (stf[m] && mh[m]) begin
        d = qd[m][mj[m]];
        d[(sa % WPB)*DW +: DW] = DW'(sd);
        qd[m][mj[m]] = d;
        qm[m][mj[m]] = qm[m][mj[m]] | (WPB'(1) << (sa % WPB));
      end
      if (fire[m]) begin
        void'(qa[m].pop_front()); void'(qm[m].pop_front());
        void'(qd[m].pop_front()); void'(qw[m].pop_front());
      end
      if (stf[m] && !mh[m]) begin
        d = '0;
        d[(sa % WPB)*DW +: DW] = DW'(sd);
        qa[m].push_back(BAW'(sa >> WO));
        qm[m].push_back(WPB'(1) << (sa % WPB));
        qd[m].push_back(d);
        qw[m].push_back(0);
      end
      dact[m] = (dact[m] || dr) && qa[m].size() != 0;
    end
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    dact[0] = 0; dact[1] = 0; prev_stall[0] = 0; prev_stall[1] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R1 empty", m, LW'(empty[m]), LW'(1));
      chk("R1 wr_valid", m, LW'(wr_valid[m]), LW'(0));
      chk("R1 ld_cmpl", m, LW'(ld_cmpl[m]), LW'(0));
      chk("R1 st_ready", m, LW'(st_ready[m]), LW'(1));
    end
    @(posedge clk); #1;
    // directed: stores, merge, youngest-match forward, partial miss
    step(1, 5, 'h11, 0, 0, 0, 0);
    step(1, 6, 'h22, 0, 0, 0, 0);
    step(1, 5, 'h33, 1, 5, 0, 0);   // R5 forward of older value
    step(0, 0, 0,    1, 5, 0, 0);   // R5 youngest value
    step(0, 0, 0,    1, 7, 0, 0);   // R6 partial miss
    step(0, 0, 0,    1, 40, 0, 0);  // R6 miss
    repeat (4) step(0, 0, 0, 0, 0, 1, 0); // R2 drains, R4 merge holds
    // fill merge buffer, then a stalled store (R8)
    for (int b = 2; b < 7; b++) step(1, b * WPB + 1, b, 1, 5, 0, 0);
    step(1, 30, 'h77, 1, 9, 0, 0);
    step(0, 0, 0, 1, 9, 0, 1);      // R9 drain request
    repeat (3) step(1, 2, 1, 1, 13, 1, 0); // R7 completion, stores refused
    repeat (8) step(0, 0, 0, 0, 0, 1, 0);
    // random traffic
    for (int c = 0; c < 4000; c++)
      step($urandom_range(0, 1), $urandom_range(0, 31), $urandom, $urandom_range(0, 1),
           $urandom_range(0, 31), $urandom_range(0, 9) < 6, $urandom_range(0, 19) == 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule